// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Polarity Control

This block produces a pulse-width modulated waveform on each of several independent channels. Each channel has a period and an active time, both counted in ticks of the input clock. Software programs the block through a single-cycle register port with a write strobe, a read strobe, a byte address and a 32-bit data word. Three control words hold one bit per channel: an inversion bit, a run bit and a pin-drive bit.

When the run bit goes from 0 to 1, the channel copies its programmed period and active time into private shadow copies. It then counts from zero. Later writes to those registers are held until software clears the run bit and sets it again. A stopped channel rests at the level its inversion bit selects. A channel whose period and active time are both zero holds its output high, whether stopped or running.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads as zero, every `pwm_oe` bit is low, and every `pwm_out` bit is high, because all timing settings are zero.
- R2: Channel n keeps its active time at byte offset n*8 and its period at n*8+4. The control words are at 0x40 (inversion), 0x44 (run) and 0xD0 (pin drive), and bit n of each belongs to channel n. A read returns the stored value on `reg_rdata` in the cycle after `reg_re`.
- R3: A stopped channel whose period or active time is nonzero drives 0 when its inversion bit is 0 and 1 when the bit is 1.
- R4: A channel whose period and active time are both zero drives 1, whether it is stopped or running.
- R5: One cycle after the run bit rises, the channel starts from a count of zero. It is at its active level for the first (active time) ticks of each period, at the other level for the rest of the period, and the pattern repeats every (period) ticks.
- R6: Writes to a running channel's period or active time leave its waveform unchanged.
- R7: Clearing the run bit returns the channel to its stopped level. Setting the bit again restarts the channel from count zero with the period and active time written most recently.
- R8: If the active time is greater than or equal to a nonzero period, the running channel stays at its active level for the whole period.
- R9: An inversion bit of 1 inverts the running waveform, so the active level is 0.
- R10: `pwm_oe[n]` equals bit n of the pin-drive word from the cycle after that word is written.
- R11: Control-word bits at positions NCH and above are not stored and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all counts are in its ticks |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_re | input | 1 | Read strobe; data appears on the following cycle |
| reg_addr | input | AW | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pwm_out | output | NCH | Waveform, one bit per channel |
| pwm_oe | output | NCH | Pin-drive enable, one bit per channel |

## Verification
The assertions assume that reads and writes use word-aligned addresses. They also assume that a readback check never overlaps a second write to the same control word. The stopped-level checks take effect only after the run bit has been low for two consecutive cycles. This gives the channel's internal run flag time to follow the run bit. The stimulus always holds a stopped state for at least one full cycle before a channel is checked in it, and it issues each register access alone in its own cycle.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int DW = 32;

    typedef logic [DW-1:0] word_t;

    // control words shared by all channels, one bit per channel
    localparam logic [7:0] OFS_POL   = 8'h40;
    localparam logic [7:0] OFS_START = 8'h44;
    localparam logic [7:0] OFS_OE    = 8'hD0;

    // programmed or shadowed timing of one channel
    typedef struct packed {
        word_t per;
        word_t act;
    } timing_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic                    re,
    input  logic [AW-1:0]           addr,
    input  word_t                   wdata,
    output word_t                   rdata,
    output timing_t [NCH-1:0]       tim,
    output logic    [NCH-1:0]       pol,
    output logic    [NCH-1:0]       start,
    output logic    [NCH-1:0]       oe
);

    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [AW-1:0] CH_END = AW'(NCH * 8);

    typedef struct packed {
        timing_t [NCH-1:0] tim;
        logic    [NCH-1:0] pol;
        logic    [NCH-1:0] start;
        logic    [NCH-1:0] oe;
        word_t             rdata;
    } regs_t;

    regs_t s_d, s_q;

    logic          chan_hit;
    logic [IW-1:0] idx;
    word_t         rd_val;

    always_comb begin
        s_d      = s_q;
        chan_hit = (addr < CH_END) && (addr[1:0] == 2'b00);
        idx      = addr[3 +: IW];
        rd_val   = '0;

        if (we) begin
            if (chan_hit) begin
                if (addr[2]) s_d.tim[idx].per = wdata;
                else         s_d.tim[idx].act = wdata;
            end else if (addr == AW'(OFS_POL)) begin
                s_d.pol = wdata[NCH-1:0];
            end else if (addr == AW'(OFS_START)) begin
                s_d.start = wdata[NCH-1:0];
            end else if (addr == AW'(OFS_OE)) begin
                s_d.oe = wdata[NCH-1:0];
            end
        end

        if (chan_hit) begin
            rd_val = addr[2] ? s_q.tim[idx].per : s_q.tim[idx].act;
        end else if (addr == AW'(OFS_POL)) begin
            rd_val = DW'(s_q.pol);
        end else if (addr == AW'(OFS_START)) begin
            rd_val = DW'(s_q.start);
        end else if (addr == AW'(OFS_OE)) begin
            rd_val = DW'(s_q.oe);
        end

        if (re) s_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tim   = s_q.tim;
    assign pol   = s_q.pol;
    assign start = s_q.start;
    assign oe    = s_q.oe;
    assign rdata = s_q.rdata;

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_bank_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    pol,
    input  timing_t live,
    output logic    wave
);

    typedef struct packed {
        word_t per;
        word_t act;
        word_t cnt;
        logic  run;
    } chan_t;

    chan_t c_d, c_q;

    logic live_zero;
    logic shadow_zero;
    logic raw;

    always_comb begin
        c_d     = c_q;
        c_d.run = start;

        if (start && !c_q.run) begin
            // rising run bit: capture timing, restart count
            c_d.per = live.per;
            c_d.act = live.act;
            c_d.cnt = '0;
        end else if (start && c_q.run) begin
            if (c_q.per == '0 || c_q.cnt == c_q.per - 1'b1) c_d.cnt = '0;
            else                                          c_d.cnt = c_q.cnt + 1'b1;
        end

        live_zero   = (live.per == '0) && (live.act == '0);
        shadow_zero = (c_q.per == '0) && (c_q.act == '0);
        raw         = (c_q.cnt < c_q.act);

        if (c_q.run) wave = shadow_zero ? 1'b1 : (raw ^ pol);
        else         wave = live_zero   ? 1'b1 : pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [AW-1:0]     reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NCH-1:0]    pwm_out,
    output logic [NCH-1:0]    pwm_oe
);

    timing_t [NCH-1:0] tim_w;
    logic    [NCH-1:0] pol_w;
    logic    [NCH-1:0] start_w;
    logic    [NCH-1:0] oe_w;

    pwm_regs #(
        .NCH (NCH),
        .AW  (AW)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .re    (reg_re),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .tim   (tim_w),
        .pol   (pol_w),
        .start (start_w),
        .oe    (oe_w)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_chan u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .start (start_w[g]),
            .pol   (pol_w[g]),
            .live  (tim_w[g]),
            .wave  (pwm_out[g])
        );
    end

    assign pwm_oe = oe_w;

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [AW-1:0]     reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [31:0]       reg_rdata,
    input  logic [NCH-1:0]    pwm_out,
    input  logic [NCH-1:0]    pwm_oe,
    input  timing_t [NCH-1:0] tim,
    input  logic [NCH-1:0]    pol,
    input  logic [NCH-1:0]    start
);

    // R1: a reset cycle clears pin drive and read data
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pwm_oe == '0 && reg_rdata == '0));

    // R10: pin-drive word appears on the pins one cycle after the write
    p_oe_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == AW'(OFS_OE)) |=> pwm_oe == $past(reg_wdata[NCH-1:0]));

    // R2: inversion word read straight after its write returns the written bits
    p_pol_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == AW'(OFS_POL))
        ##1 (reg_re && !reg_we && reg_addr == AW'(OFS_POL))
        |=> reg_rdata == 32'($past(reg_wdata[NCH-1:0], 2)));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R3: stopped channel with nonzero timing rests at the inversion level
        p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!start[i] && !$past(start[i]) && !(tim[i].per == '0 && tim[i].act == '0))
            |-> pwm_out[i] == pol[i]);

        // R4: stopped channel with all-zero timing is high
        p_zero_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!start[i] && !$past(start[i]) && tim[i].per == '0 && tim[i].act == '0)
            |-> pwm_out[i]);
    end

endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out),
    .pwm_oe    (pwm_oe),
    .tim       (tim_w),
    .pol       (pol_w),
    .start     (start_w)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NCH-1:0] pwm_out;
    logic [NCH-1:0] pwm_oe;

    pwm_bank #(.NCH(NCH), .AW(8)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out),
        .pwm_oe    (pwm_oe)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // kind 0: pwm_out, 1: pwm_oe, 2: reg_rdata
    typedef struct {
        int          kind;
        int          at;
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } item_t;

    item_t sb[$];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // monitor: compares scoreboard items at their cycle
    always begin : monitor
        item_t       it;
        logic [31:0] got;
        @(negedge clk);
        #2;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            it = sb.pop_front();
            case (it.kind)
                0:       got = 32'(pwm_out);
                1:       got = 32'(pwm_oe);
                default: got = reg_rdata;
            endcase
            n_chk++;
            if (it.at < cyc) begin
                n_fail++;
                $display("FAIL %s: item for cycle %0d missed at %0d (actual %h expected %h)",
                         it.tag, it.at, cyc, got & it.mask, it.exp & it.mask);
            end else if ((got & it.mask) !== (it.exp & it.mask)) begin
                n_fail++;
                $display("FAIL %s: cycle %0d actual %h expected %h",
                         it.tag, cyc, got & it.mask, it.exp & it.mask);
            end
        end
    end

    task automatic push(input int kind, input int at, input logic [31:0] exp,
                        input logic [31:0] mask, input string tag);
        item_t it;
        it.kind = kind; it.at = at; it.exp = exp; it.mask = mask; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_re = 1'b1; reg_addr = a;
        push(2, cyc + 1, exp, 32'hFFFF_FFFF, tag);
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic wave(input int s, input int n, input int per, input int act,
                        input int ch, input bit inv, input string tag);
        for (int k = 0; k < n; k++) begin
            bit v;
            v = ((k % per) < act) ^ inv;
            push(0, s + k, 32'(v) << ch, 32'(1) << ch, tag);
        end
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : driver
        int s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state (R4: zero settings drive high)
        push(0, cyc + 1, 32'hF, 32'hF, "R1 out after reset");
        push(1, cyc + 1, 32'h0, 32'hF, "R1 oe after reset");
        @(negedge clk);
        rd(8'h44, 32'h0, "R1 run word after reset");
        rd(8'h0C, 32'h0, "R1 period ch1 after reset");

        // R2 register map
        wr(8'h00, 32'd3);
        wr(8'h04, 32'd8);
        rd(8'h00, 32'd3, "R2 ch0 active readback");
        rd(8'h04, 32'd8, "R2 ch0 period readback");

        // R3 stopped level, normal polarity; R4 ch1 zero settings high
        push(0, cyc + 1, 32'h2, 32'h3, "R3 R4 stopped levels pol=0");
        @(negedge clk);
        wr(8'h40, 32'hFFFF_FFFF);
        push(0, cyc + 1, 32'h3, 32'h3, "R3 stopped level pol=1");
        @(negedge clk);
        rd(8'h40, 32'h0000_000F, "R11 upper control bits dropped");
        wr(8'h40, 32'h0);
        push(0, cyc + 1, 32'h2, 32'h3, "R4 zero settings high pol=0");
        @(negedge clk);

        // R5 start ch0: act 3, per 8
        wr(8'h44, 32'h1);
        s = cyc + 1;
        wave(s, 60, 8, 3, 0, 1'b0, "R5 ch0 waveform");
        repeat (5) @(negedge clk);
        // R6 writes while running are held back
        wr(8'h00, 32'd5);
        wr(8'h04, 32'd6);
        drain();

        // R7 stop then restart adopts new values
        wr(8'h44, 32'h0);
        push(0, cyc + 1, 32'h0, 32'h1, "R7 stopped level between runs");
        wr(8'h44, 32'h1);
        s = cyc + 1;
        wave(s, 30, 6, 5, 0, 1'b0, "R7 ch0 new waveform");
        drain();

        // R8 ch2 active >= period; R4 ch3 running with zero settings
        wr(8'h10, 32'd10);
        wr(8'h14, 32'd4);
        wr(8'h44, 32'hD);
        s = cyc + 1;
        for (int k = 0; k < 12; k++)
            push(0, s + k, 32'hC, 32'hC, "R8 R4 ch2 full active, ch3 zero high");
        drain();

        // R9 ch1 inverted: act 2, per 5
        wr(8'h08, 32'd2);
        wr(8'h0C, 32'd5);
        wr(8'h40, 32'h2);
        wr(8'h44, 32'hF);
        s = cyc + 1;
        wave(s, 20, 5, 2, 1, 1'b1, "R9 ch1 inverted waveform");
        drain();

        // R10 pin drive
        wr(8'hD0, 32'hA);
        push(1, cyc + 1, 32'hA, 32'hF, "R10 oe follows word");
        @(negedge clk);
        rd(8'hD0, 32'hA, "R10 oe word readback");
        wr(8'hD0, 32'h5);
        push(1, cyc + 1, 32'h5, 32'hF, "R10 oe second pattern");
        @(negedge clk);
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule